// File: doc/BRIEF.md
# Display Driver Power-Up and Identity Check

This block brings an external display driver chip out of reset and checks what it is before any panel configuration runs. After a start pulse it works two active-low control lines, a protect line and a reset line, so that the reset pulse sits inside a window where protect is released. Each step is followed by a fixed wait.

It then uses a command/data bus to clear the chip's access protection, wake it from deep standby and ask for its identification code. After a long settle time it does one read and throws the result away. It then builds a 32-bit identifier from four further reads and compares it with an expected constant. The result is reported as a done flag plus a detected flag. Both flags hold until the next start.

Every wait is a cycle count derived from a `CLK_HZ` parameter. A `TIME_DIV` parameter shrinks the waits for fast simulation. The bus is a request/acknowledge port with a register-select bit and a write/read bit.

Top module: `panel_id_seq`

Wait lengths in cycles: `T_RST` = 1100 µs, `T_REC` = 10 µs, `T_SETTLE` = 20000 µs and `T_ID` = 50000 µs. Each is scaled as (CLK_HZ/10^6)·µs/TIME_DIV, with a minimum of 1.

## Requirements
- R1: After an accepted start, `prot_n_o` goes low one cycle after the start edge. `lcd_rst_n_o` goes low one cycle later. `prot_n_o` returns high one cycle after that.
- R2: Reset stays low with protect high for exactly `T_RST` cycles. Reset is then released. Protect stays high for exactly `T_REC` more cycles, then goes low and stays low.
- R3: The first bus request rises `T_SETTLE`+1 cycles after protect falls. No bus request is ever made while reset is low or protect is high.
- R4: A transfer with `bus_rs_o`=0 is a command write (`bus_we_o`=1) whose 8-bit code is in `bus_wdata_o[7:0]`, with the upper bits zero. `bus_rs_o`=1 marks a parameter. `bus_we_o`=0 marks a read, which drives `bus_wdata_o`=0. The order is: command 0xB0, parameter 0x00, command 0xB1, parameter 0x00, command 0xBF, then five reads.
- R5: The request that follows command 0xBF rises `T_ID`+1 cycles after the 0xBF request drops.
- R6: The first read is discarded. Of the next four reads only `bus_rdata_i[7:0]` is kept, and the first of them becomes bits 31:24 of the identifier. Bits 17:8 have no effect.
- R7: `detected_o` is 1 exactly when the identifier equals `ID_EXPECT` (default 0x01221517).
- R8: A request holds `bus_req_o`, `bus_rs_o`, `bus_we_o` and `bus_wdata_o` unchanged until the cycle in which `bus_ack_i` is high. It drops on the next edge. Only one transfer is ever outstanding.
- R9: `done_o` is low from the cycle after an accepted start until the sequence ends. `done_o` and `detected_o` then hold until the next start.
- R10: A start while a sequence is running is ignored. It changes neither the control lines nor the transfer order or count.
- R11: In reset, `prot_n_o`=1, `lcd_rst_n_o`=1, `bus_req_o`=0, `done_o`=0 and `detected_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a power-up and identity check |
| prot_n_o | output | 1 | Protect line to the driver chip, active low |
| lcd_rst_n_o | output | 1 | Reset line to the driver chip, active low |
| bus_req_o | output | 1 | Transfer request, held until acknowledged |
| bus_rs_o | output | 1 | Register select: 0 command, 1 parameter/data |
| bus_we_o | output | 1 | 1 write, 0 read |
| bus_wdata_o | output | DATA_W | Write value: command code or parameter |
| bus_rdata_i | input | DATA_W | Read value, sampled when acknowledged |
| bus_ack_i | input | 1 | Transfer complete |
| done_o | output | 1 | Sequence finished |
| detected_o | output | 1 | Identifier matched (valid with done_o) |

## Verification
The assertions assume that `bus_ack_i` is raised only while a request is pending and lasts exactly one cycle. They also assume that `bus_rdata_i` is valid in that same cycle. The bench's bus responder follows these rules: it answers a request only after seeing it, waits zero to two cycles in rotation, and pulses the acknowledge for one cycle. The stray start is issued while protect is high and reset is held low, so it lands inside the active sequence.

// File: rtl/panel_id_pkg.sv
package panel_id_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PROT_LO,
    ST_RST_LO,
    ST_HOLD,
    ST_RECOVER,
    ST_SETTLE,
    ST_ISSUE,
    ST_XFER,
    ST_ID_WAIT
  } seq_state_e;

  typedef struct packed {
    logic       rs;
    logic       we;
    logic [7:0] code;
  } bus_op_t;

  localparam int unsigned N_OPS     = 10;
  localparam int unsigned OP_ID_REQ = 4;
  localparam int unsigned OP_DUMMY  = 5;

  localparam logic [7:0] CMD_UNPROTECT = 8'hB0;
  localparam logic [7:0] CMD_WAKE      = 8'hB1;
  localparam logic [7:0] CMD_READ_ID   = 8'hBF;

  // fixed transfer list: two unlock/wake pairs, id request, five reads
  function automatic bus_op_t op_at(input logic [3:0] idx);
    bus_op_t op;
    case (idx)
      4'd0:    op = '{rs: 1'b0, we: 1'b1, code: CMD_UNPROTECT};
      4'd1:    op = '{rs: 1'b1, we: 1'b1, code: 8'h00};
      4'd2:    op = '{rs: 1'b0, we: 1'b1, code: CMD_WAKE};
      4'd3:    op = '{rs: 1'b1, we: 1'b1, code: 8'h00};
      4'd4:    op = '{rs: 1'b0, we: 1'b1, code: CMD_READ_ID};
      default: op = '{rs: 1'b1, we: 1'b0, code: 8'h00};
    endcase
    return op;
  endfunction

  function automatic int unsigned us_to_cycles(input longint unsigned clk_hz,
                                               input longint unsigned div,
                                               input longint unsigned us);
    longint unsigned c;
    c = ((clk_hz / 64'd1_000_000) * us) / div;
    return (c < 64'd1) ? 1 : int'(c);
  endfunction

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  // R2: once run out, stays run out until reloaded
  a_r2_timer_stays_expired: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && expired_o |=> expired_o);

endmodule

// File: rtl/bus_xfer.sv
module bus_xfer
  import panel_id_pkg::*;
#(
  parameter int unsigned DATA_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  bus_op_t           op_i,
  output logic              req_o,
  output logic              rs_o,
  output logic              we_o,
  output logic [DATA_W-1:0] wdata_o,
  input  logic              ack_i,
  output logic              fin_o
);

  logic              req_q, rs_q, we_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      rs_q   <= 1'b0;
      we_q   <= 1'b0;
      data_q <= '0;
    end else if (issue_i && !req_q) begin
      req_q  <= 1'b1;
      rs_q   <= op_i.rs;
      we_q   <= op_i.we;
      data_q <= DATA_W'(op_i.code);
    end else if (req_q && ack_i) begin
      req_q  <= 1'b0;
    end
  end

  assign req_o   = req_q;
  assign rs_o    = rs_q;
  assign we_o    = we_q;
  assign wdata_o = data_q;
  assign fin_o   = req_q && ack_i;

  // R8: fields frozen while waiting
  a_r8_hold_until_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i |=> req_o && $stable(rs_o) && $stable(we_o) && $stable(wdata_o));

  // R8: never issue over an outstanding transfer
  a_r8_single_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |-> !req_o);

endmodule

// File: rtl/id_shift.sv
module id_shift #(
  parameter int unsigned ID_W   = 32,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              shift_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [ID_W-1:0]   value_o
);

  logic [ID_W-1:0] val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      val_q <= '0;
    else if (clear_i) val_q <= '0;
    else if (shift_i) val_q <= {val_q[ID_W-BYTE_W-1:0], byte_i};
  end

  assign value_o = val_q;

  // R6: value only moves on a kept read or a clear
  a_r6_value_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i && !shift_i |=> $stable(value_o));

endmodule

// File: rtl/panel_id_seq.sv
module panel_id_seq
  import panel_id_pkg::*;
#(
  parameter longint unsigned CLK_HZ    = 50_000_000,
  parameter longint unsigned TIME_DIV  = 1,
  parameter int unsigned     DATA_W    = 18,
  parameter logic [31:0]     ID_EXPECT = 32'h0122_1517
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              prot_n_o,
  output logic              lcd_rst_n_o,
  output logic              bus_req_o,
  output logic              bus_rs_o,
  output logic              bus_we_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_ack_i,
  output logic              done_o,
  output logic              detected_o
);

  localparam int unsigned T_RST    = us_to_cycles(CLK_HZ, TIME_DIV, 1100);
  localparam int unsigned T_REC    = us_to_cycles(CLK_HZ, TIME_DIV, 10);
  localparam int unsigned T_SETTLE = us_to_cycles(CLK_HZ, TIME_DIV, 20000);
  localparam int unsigned T_ID     = us_to_cycles(CLK_HZ, TIME_DIV, 50000);
  localparam int unsigned T_MAX    = (T_ID > T_SETTLE) ? T_ID : T_SETTLE;
  localparam int unsigned CNT_W    = $clog2(T_MAX + 1);
  localparam int unsigned ID_W     = 32;
  localparam int unsigned BYTE_W   = 8;

  seq_state_e        state_q;
  logic [3:0]        op_q;
  logic              prot_q, lrst_q, done_q;
  logic              tmr_load, tmr_exp;
  logic [CNT_W-1:0]  tmr_val;
  logic              issue, fin, shift, clear;
  logic [ID_W-1:0]   id_val;

  assign issue = (state_q == ST_ISSUE);
  assign clear = (state_q == ST_IDLE) && start_i;
  assign shift = (state_q == ST_XFER) && fin && (op_q > 4'(OP_DUMMY));

  // reload so that each wait state lasts exactly its interval
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_RST_LO: begin
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(T_RST - 1);
      end
      ST_HOLD: if (tmr_exp) begin
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(T_REC - 1);
      end
      ST_RECOVER: if (tmr_exp) begin
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(T_SETTLE - 1);
      end
      ST_XFER: if (fin && op_q == 4'(OP_ID_REQ)) begin
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(T_ID - 1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= '0;
      prot_q  <= 1'b1;
      lrst_q  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          prot_q  <= 1'b0;
          done_q  <= 1'b0;
          op_q    <= '0;
          state_q <= ST_PROT_LO;
        end
        ST_PROT_LO: begin
          lrst_q  <= 1'b0;
          state_q <= ST_RST_LO;
        end
        ST_RST_LO: begin
          prot_q  <= 1'b1;
          state_q <= ST_HOLD;
        end
        ST_HOLD: if (tmr_exp) begin
          lrst_q  <= 1'b1;
          state_q <= ST_RECOVER;
        end
        ST_RECOVER: if (tmr_exp) begin
          prot_q  <= 1'b0;
          state_q <= ST_SETTLE;
        end
        ST_SETTLE: if (tmr_exp) state_q <= ST_ISSUE;
        ST_ISSUE:  state_q <= ST_XFER;
        ST_XFER: if (fin) begin
          if (op_q == 4'(N_OPS - 1)) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            op_q    <= op_q + 1'b1;
            state_q <= (op_q == 4'(OP_ID_REQ)) ? ST_ID_WAIT : ST_ISSUE;
          end
        end
        ST_ID_WAIT: if (tmr_exp) state_q <= ST_ISSUE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expired_o  (tmr_exp)
  );

  bus_xfer #(.DATA_W(DATA_W)) u_xfer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .issue_i (issue),
    .op_i    (op_at(op_q)),
    .req_o   (bus_req_o),
    .rs_o    (bus_rs_o),
    .we_o    (bus_we_o),
    .wdata_o (bus_wdata_o),
    .ack_i   (bus_ack_i),
    .fin_o   (fin)
  );

  id_shift #(.ID_W(ID_W), .BYTE_W(BYTE_W)) u_id (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .shift_i (shift),
    .byte_i  (bus_rdata_i[BYTE_W-1:0]),
    .value_o (id_val)
  );

  assign prot_n_o    = prot_q;
  assign lcd_rst_n_o = lrst_q;
  assign done_o      = done_q;
  assign detected_o  = done_q && (id_val == ID_EXPECT);

  // R1: reset asserted only inside the protect-low window
  a_r1_rst_inside_protect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lcd_rst_n_o) |-> !prot_n_o);

  // R2: reset released while protect is high
  a_r2_release_under_protect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lcd_rst_n_o) |-> prot_n_o);

  // R3: no bus traffic unless chip is out of reset and protect is low
  a_r3_bus_quiet_in_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> lcd_rst_n_o && !prot_n_o);

  // R4: commands are always writes
  a_r4_cmd_is_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_rs_o |-> bus_we_o);

  // R9: result holds until a new start
  a_r9_result_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o && $stable(detected_o));

  // R10: start while busy does not restart
  a_r10_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) && start_i |=> (state_q != ST_PROT_LO));

endmodule

// File: tb/tb_panel_id_seq.sv
`timescale 1ns/1ps
module tb_panel_id_seq;

  localparam longint unsigned CLK_HZ   = 200_000_000;
  localparam longint unsigned TIME_DIV = 1000;
  localparam int DW = 18;
  // 200 cycles/us scaled by 1/1000
  localparam int E_RST    = 220;
  localparam int E_REC    = 2;
  localparam int E_SETTLE = 4000;
  localparam int E_ID     = 10000;
  localparam int WDOG     = 190_000;

  typedef struct packed {
    logic          rs;
    logic          we;
    logic [DW-1:0] data;
  } xfer_t;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic          prot_n_o, lcd_rst_n_o, bus_req_o, bus_rs_o, bus_we_o;
  logic [DW-1:0] bus_wdata_o;
  logic [DW-1:0] bus_rdata_i = '1;
  logic          bus_ack_i = 1'b0;
  logic          done_o, detected_o;

  panel_id_seq #(.CLK_HZ(CLK_HZ), .TIME_DIV(TIME_DIV), .DATA_W(DW)) dut (
    .clk_i, .rst_ni, .start_i, .prot_n_o, .lcd_rst_n_o, .bus_req_o, .bus_rs_o,
    .bus_we_o, .bus_wdata_o, .bus_rdata_i, .bus_ack_i, .done_o, .detected_o
  );

  always #2.5 clk_i = ~clk_i;

  int    n_chk = 0;
  int    n_bad = 0;
  int    cyc   = 0;
  xfer_t exp_q[$];
  logic [DW-1:0] rd_data [5];
  int    rd_idx = 0;
  int    n_xfer = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc == WDOG) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, WDOG);
      finish_run();
    end
  end

  // timing monitor, sampled on the falling edge
  logic p_prot = 1'b1, p_rst = 1'b1, p_req = 1'b0;
  int t_prot_hi = 0, t_rst_hi = 0, t_prot_lo = 0, t_bf = 0;
  bit settle_pend = 0, id_pend = 0;
  int req_falls = 0, rf_base = 0;
  int dur_rst = -1, dur_rec = -1, dur_settle = -1, dur_id = -1;

  always @(negedge clk_i) begin
    if (!p_prot && prot_n_o) t_prot_hi = cyc;
    if (!p_rst && lcd_rst_n_o) begin
      dur_rst  = cyc - t_prot_hi;
      t_rst_hi = cyc;
    end
    if (p_prot && !prot_n_o && lcd_rst_n_o) begin
      dur_rec     = cyc - t_rst_hi;
      t_prot_lo   = cyc;
      settle_pend = 1;
    end
    if (!p_req && bus_req_o) begin
      if (settle_pend) begin
        dur_settle  = cyc - t_prot_lo;
        settle_pend = 0;
      end
      if (id_pend) begin
        dur_id  = cyc - t_bf;
        id_pend = 0;
      end
    end
    if (p_req && !bus_req_o) begin
      req_falls++;
      if (req_falls - rf_base == 5) begin
        t_bf    = cyc;
        id_pend = 1;
      end
    end
    p_prot = prot_n_o;
    p_rst  = lcd_rst_n_o;
    p_req  = bus_req_o;
  end

  // bus responder and scoreboard monitor
  xfer_t got, want;
  int    dly;
  bit    held;
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni && bus_req_o && !bus_ack_i) begin
        got  = '{rs: bus_rs_o, we: bus_we_o, data: bus_wdata_o};
        dly  = n_xfer % 3;
        held = 1;
        for (int i = 0; i < dly; i++) begin
          @(negedge clk_i);
          if (!bus_req_o || got != xfer_t'({bus_rs_o, bus_we_o, bus_wdata_o})) held = 0;
        end
        n_xfer++;
        if (exp_q.size() == 0) begin
          check(0, "R10", "unexpected extra transfer", longint'(got), 0);
        end else begin
          want = exp_q.pop_front();
          check(got == want, "R4", "transfer rs/we/data", longint'(got), longint'(want));
        end
        check(held, "R8", "request held until ack", held, 1);
        if (!got.we && rd_idx < 5) begin
          bus_rdata_i = rd_data[rd_idx];
          rd_idx++;
        end
        bus_ack_i = 1'b1;
        @(negedge clk_i);
        bus_ack_i   = 1'b0;
        bus_rdata_i = '1;
      end
    end
  end

  task automatic push_expected();
    exp_q.push_back('{rs: 1'b0, we: 1'b1, data: 18'h000B0});
    exp_q.push_back('{rs: 1'b1, we: 1'b1, data: 18'h00000});
    exp_q.push_back('{rs: 1'b0, we: 1'b1, data: 18'h000B1});
    exp_q.push_back('{rs: 1'b1, we: 1'b1, data: 18'h00000});
    exp_q.push_back('{rs: 1'b0, we: 1'b1, data: 18'h000BF});
    for (int i = 0; i < 5; i++) exp_q.push_back('{rs: 1'b1, we: 1'b0, data: 18'h00000});
  endtask

  task automatic run(input logic [DW-1:0] rd [5], input bit exp_det,
                     input bit poke, input string tag);
    rd_data = rd;
    rd_idx  = 0;
    n_xfer  = 0;
    rf_base = req_falls;
    dur_rst = -1; dur_rec = -1; dur_settle = -1; dur_id = -1;
    push_expected();
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
    check(!prot_n_o && lcd_rst_n_o, "R1", {tag, " protect low first"}, {prot_n_o, lcd_rst_n_o}, 2'b01);
    check(!done_o, "R9", {tag, " done cleared on start"}, done_o, 0);
    @(negedge clk_i);
    check(!prot_n_o && !lcd_rst_n_o, "R1", {tag, " reset low second"}, {prot_n_o, lcd_rst_n_o}, 2'b00);
    @(negedge clk_i);
    check(prot_n_o && !lcd_rst_n_o, "R1", {tag, " protect high third"}, {prot_n_o, lcd_rst_n_o}, 2'b10);
    if (poke) begin
      repeat (50) @(negedge clk_i);
      start_i = 1'b1;
      @(negedge clk_i) start_i = 1'b0;
      @(negedge clk_i);
      check(prot_n_o && !lcd_rst_n_o, "R10", {tag, " start mid-run ignored"}, {prot_n_o, lcd_rst_n_o}, 2'b10);
    end
    while (!done_o) @(negedge clk_i);
    check(dur_rst == E_RST, "R2", {tag, " reset hold"}, dur_rst, E_RST);
    check(dur_rec == E_REC, "R2", {tag, " recovery"}, dur_rec, E_REC);
    check(dur_settle == E_SETTLE + 1, "R3", {tag, " settle to first request"}, dur_settle, E_SETTLE + 1);
    check(dur_id == E_ID + 1, "R5", {tag, " id wait"}, dur_id, E_ID + 1);
    check(detected_o == exp_det, "R7", {tag, " detected"}, detected_o, exp_det);
    check(n_xfer == 10 && exp_q.size() == 0, poke ? "R10" : "R4", {tag, " transfer count"}, n_xfer, 10);
    repeat (20) @(negedge clk_i);
    check(done_o && detected_o == exp_det && !bus_req_o, "R9", {tag, " result held"},
          {done_o, detected_o, bus_req_o}, {1'b1, exp_det, 1'b0});
    exp_q.delete();
  endtask

  initial begin
    repeat (4) @(negedge clk_i);
    check(prot_n_o && lcd_rst_n_o && !bus_req_o && !done_o && !detected_o, "R11", "reset state",
          {prot_n_o, lcd_rst_n_o, bus_req_o, done_o, detected_o}, 5'b11000);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);

    run('{18'h000AA, 18'h00001, 18'h00022, 18'h00015, 18'h00017}, 1'b1, 1'b0, "match");
    run('{18'h00055, 18'h00001, 18'h00022, 18'h00015, 18'h00018}, 1'b0, 1'b0, "wrong-byte");
    // R6: upper bits of each read are junk
    run('{18'h3FF00, 18'h3FF01, 18'h2AB22, 18'h10015, 18'h3FF17}, 1'b1, 1'b0, "high-bits");
    // R6: id bytes placed in the dummy slot must not count
    run('{18'h00001, 18'h00022, 18'h00015, 18'h00017, 18'h00000}, 1'b0, 1'b1, "dummy-align");
    run('{18'h00017, 18'h00001, 18'h00022, 18'h00015, 18'h00017}, 1'b1, 1'b0, "rematch");

    finish_run();
  end

endmodule